// File: doc/BRIEF.md
# Iterative Row-Column Product Code Decoder

This block corrects a 16 by 16 frame of hard-decision bits in which every row and every column is an extended Hamming (16,11) word. A frame is written in row by row through a load port. The block then runs iterations. Each iteration first corrects every row, one per cycle, and then every column, one per cycle. After each iteration it counts how many of the 32 component words still carry a nonzero syndrome. It stops as soon as that count is zero or the iteration cap is reached. It then streams the frame out, row by row, together with the number of iterations spent, the residual word count and a failure flag.

Information bits sit at the 11 non-parity positions of each word, so the 121 data bits form an 11 by 11 array. The parity rows and parity columns cross in 25 check-on-check cells. There is no flow control: the receiver must accept each output row in the cycle it appears. Load beats that arrive while a frame is being decoded or streamed are dropped.

Top module: `prodcode_iter_dec`

## Requirements
- R1: Bit i of a row word belongs to column i, and bit r of a column word is row r. In each 16-bit word, position 0 is the overall parity bit and positions 1, 2, 4 and 8 are check bits. The syndrome is the XOR of the indices 1..15 of all set bits, and the word parity is the XOR of all 16 bits.
- R2: In the idle or loading state, each beat with `in_valid` high writes `in_row` to the next row, starting at row 0. The beat that also has `in_last` high starts decoding. Beats arriving while decoding or streaming are ignored.
- R3: A word with odd parity is corrected by inverting the bit at the syndrome index, which is bit 0 when the syndrome is zero.
- R4: A word with even parity and a nonzero syndrome (a double error) is left unchanged in that pass.
- R5: An iteration is a row pass over rows 0..15 followed by a column pass over columns 0..15, one word per cycle, and then one check cycle: 33 cycles in all. The first output row appears 33*k clock cycles after the edge that takes the last load beat, where k is the number of iterations run.
- R6: When every row and column has zero syndrome and even parity after an iteration, decoding stops and the frame is output at once.
- R7: The iteration cap is taken from `max_iter` on the last load beat. A value of 0 is treated as 1, and a value above 6 is treated as 6.
- R8: The output is 16 consecutive cycles with `out_valid` high, carrying rows 0..15 in order. `out_last` is high only on row 15, and `out_valid` falls in the following cycle.
- R9: `iters_used` gives the number of iterations run. `resid_words` gives the number of rows plus columns whose syndrome or parity was nonzero at the final check. `fail` is high when that number is nonzero. All three are held from the first output row until the first beat of the next frame, which clears them to zero.
- R10: After reset, `out_valid`, `out_last`, `iters_used`, `resid_words` and `fail` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load beat strobe |
| in_row | input | 16 | Received row bits, bit i = column i |
| in_last | input | 1 | Marks the final row of the frame |
| max_iter | input | 3 | Iteration cap, sampled with the last beat |
| out_valid | output | 1 | Output row strobe |
| out_row | output | 16 | Corrected row bits |
| out_last | output | 1 | Marks output row 15 |
| iters_used | output | 3 | Iterations run on the frame |
| resid_words | output | 6 | Rows plus columns with nonzero syndrome at the end |
| fail | output | 1 | Frame did not converge |

## Verification
A fault in the pass sequencing shows up at the ports as a shifted start of output. This is visible on the first frame, because the first output row must arrive exactly 33 cycles after the last load beat for each iteration run. A flipped or missed correction in the frame store shows up as a wrong output row within the same frame. It also shows up as an iteration count or residual count that departs from the model, because a mistake left in one pass either forces another iteration or stalls at the cap. Errors placed to need exactly two iterations, and 2x2 squares that can never be corrected, separate the early-stop path from the cap path.

// File: rtl/prodcode_iter_dec.sv
module prodcode_iter_dec #(
  parameter int ITER_LIM = 6
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic [15:0]                        in_row,
  input  logic                               in_last,
  input  logic [$clog2(ITER_LIM+1)-1:0]      max_iter,
  output logic                               out_valid,
  output logic [15:0]                        out_row,
  output logic                               out_last,
  output logic [$clog2(ITER_LIM+1)-1:0]      iters_used,
  output logic [5:0]                         resid_words,
  output logic                               fail
);
  localparam int N  = 16;
  localparam int IW = $clog2(ITER_LIM+1);

  typedef enum logic [2:0] {IDLE, LOAD, ROW_PASS, COL_PASS, CHECK, OUTPUT} st_t;

  st_t           st;
  logic [15:0]   mem [N];
  logic [3:0]    idx;
  logic [IW-1:0] iter, cap;
  logic [15:0]   colw, colfix;
  logic [5:0]    nz;
  logic [IW-1:0] iter_n;

  function automatic logic [4:0] syn(input logic [15:0] w);
    logic [3:0] s;
    logic       p;
    s = '0;
    p = 1'b0;
    for (int i = 0; i < N; i++)
      if (w[i]) begin
        s = s ^ 4'(i);
        p = ~p;
      end
    return {p, s};
  endfunction

  function automatic logic [15:0] fix(input logic [15:0] w);
    logic [4:0] z;
    z = syn(w);
    return z[4] ? (w ^ (16'd1 << z[3:0])) : w;
  endfunction

  always_comb begin
    for (int r = 0; r < N; r++) colw[r] = mem[r][idx];
    colfix = fix(colw);
  end

  always_comb begin
    logic [15:0] cw;
    nz = '0;
    for (int i = 0; i < N; i++) begin
      if (syn(mem[i]) != 5'd0) nz = nz + 6'd1;
      for (int r = 0; r < N; r++) cw[r] = mem[r][i];
      if (syn(cw) != 5'd0) nz = nz + 6'd1;
    end
  end

  assign iter_n    = iter + IW'(1);
  assign out_valid = (st == OUTPUT);
  assign out_row   = out_valid ? mem[idx] : '0;
  assign out_last  = out_valid && (idx == 4'd15);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= IDLE;
      idx         <= '0;
      iter        <= '0;
      cap         <= IW'(1);
      iters_used  <= '0;
      resid_words <= '0;
      fail        <= 1'b0;
    end else begin
      case (st)
        IDLE, LOAD: if (in_valid) begin
          mem[idx] <= in_row;
          if (st == IDLE) begin
            iters_used  <= '0;
            resid_words <= '0;
            fail        <= 1'b0;
          end
          if (in_last) begin
            st   <= ROW_PASS;
            idx  <= '0;
            iter <= '0;
            cap  <= (max_iter == '0) ? IW'(1) :
                    (max_iter > IW'(ITER_LIM)) ? IW'(ITER_LIM) : max_iter;
          end else begin
            st  <= LOAD;
            idx <= idx + 4'd1;
          end
        end
        ROW_PASS: begin
          mem[idx] <= fix(mem[idx]);
          idx      <= idx + 4'd1;
          if (idx == 4'd15) st <= COL_PASS;
        end
        COL_PASS: begin
          for (int r = 0; r < N; r++) mem[r][idx] <= colfix[r];
          idx <= idx + 4'd1;
          if (idx == 4'd15) st <= CHECK;
        end
        CHECK: begin
          iter <= iter_n;
          if (nz == 6'd0 || iter_n == cap) begin
            st          <= OUTPUT;
            iters_used  <= iter_n;
            resid_words <= nz;
            fail        <= (nz != 6'd0);
          end else begin
            st <= ROW_PASS;
          end
        end
        OUTPUT: begin
          idx <= idx + 4'd1;
          if (idx == 4'd15) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prodcode_iter_dec_chk.sv
module prodcode_iter_dec_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_valid,
  input logic          out_last,
  input logic [IW-1:0] iters_used,
  input logic [5:0]    resid_words,
  input logic          fail,
  input logic [IW-1:0] cap
);
  assert_last_in_stream_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  assert_stream_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid);

  assert_iters_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (iters_used >= IW'(1) && iters_used <= cap));

  assert_fail_only_at_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fail) |-> (iters_used == cap));

  assert_status_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> ($stable(iters_used) && $stable(fail) && $stable(resid_words)));
endmodule

bind prodcode_iter_dec prodcode_iter_dec_chk #(.IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_last(out_last),
  .iters_used(iters_used), .resid_words(resid_words), .fail(fail), .cap(cap)
);

// File: tb/prodcode_iter_dec_tb_top.sv
module prodcode_iter_dec_tb_top;
  typedef logic [15:0] frm_t [16];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_row = '0;
  logic        in_last = 1'b0;
  logic [2:0]  max_iter = 3'd6;
  logic        out_valid;
  logic [15:0] out_row;
  logic        out_last;
  logic [2:0]  iters_used;
  logic [5:0]  resid_words;
  logic        fail;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  prodcode_iter_dec dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_row(in_row), .in_last(in_last),
    .max_iter(max_iter), .out_valid(out_valid), .out_row(out_row), .out_last(out_last),
    .iters_used(iters_used), .resid_words(resid_words), .fail(fail)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit is_chk(input int i);
    return i == 0 || i == 1 || i == 2 || i == 4 || i == 8;
  endfunction

  function automatic logic [3:0] m_pos(input logic [15:0] w);
    logic [3:0] s;
    for (int k = 0; k < 4; k++) begin
      s[k] = 1'b0;
      for (int i = 1; i < 16; i++) if (((i >> k) & 1) == 1) s[k] = s[k] ^ w[i];
    end
    return s;
  endfunction

  function automatic bit m_bad(input logic [15:0] w);
    return (^w) || (m_pos(w) != 4'd0);
  endfunction

  function automatic logic [15:0] m_fix(input logic [15:0] w);
    logic [15:0] v;
    v = w;
    if (^w) v[m_pos(w)] = ~v[m_pos(w)];
    return v;
  endfunction

  function automatic logic [15:0] enc(input logic [10:0] d);
    logic [15:0] w;
    logic [3:0]  p;
    int j;
    w = '0;
    j = 0;
    for (int i = 1; i < 16; i++) if (!is_chk(i)) begin w[i] = d[j]; j++; end
    p = m_pos(w);
    w[1] = p[0]; w[2] = p[1]; w[4] = p[2]; w[8] = p[3];
    w[0] = ^w[15:1];
    return w;
  endfunction

  task automatic make_frame(output frm_t f);
    logic [10:0] d;
    logic [15:0] cw;
    int j;
    for (int r = 0; r < 16; r++) f[r] = is_chk(r) ? 16'h0 : enc(11'($urandom));
    for (int c = 0; c < 16; c++) begin
      j = 0;
      for (int r = 0; r < 16; r++) if (!is_chk(r)) begin d[j] = f[r][c]; j++; end
      cw = enc(d);
      for (int r = 0; r < 16; r++) if (is_chk(r)) f[r][c] = cw[r];
    end
  endtask

  task automatic model(input frm_t f, input int mi, output frm_t o, output int it, output int rs);
    int cp;
    logic [15:0] cw;
    cp = (mi == 0) ? 1 : (mi > 6) ? 6 : mi;
    o = f;
    it = 0;
    rs = 0;
    for (int n = 1; n <= cp; n++) begin
      for (int r = 0; r < 16; r++) o[r] = m_fix(o[r]);
      for (int c = 0; c < 16; c++) begin
        for (int r = 0; r < 16; r++) cw[r] = o[r][c];
        cw = m_fix(cw);
        for (int r = 0; r < 16; r++) o[r][c] = cw[r];
      end
      rs = 0;
      for (int i = 0; i < 16; i++) begin
        if (m_bad(o[i])) rs++;
        for (int r = 0; r < 16; r++) cw[r] = o[r][i];
        if (m_bad(cw)) rs++;
      end
      it = n;
      if (rs == 0) break;
    end
  endtask

  task automatic run_dec(input frm_t f, input int mi, input bit junk,
                         output frm_t got, output int it, output int rs, output int fl, output int lat);
    bit seq_ok;
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      in_valid = 1'b1; in_row = f[r]; in_last = (r == 15); max_iter = 3'(mi);
    end
    @(posedge clk);
    lat = 0;
    forever begin
      @(negedge clk);
      in_valid = junk && (lat < 10);
      in_row   = 16'($urandom);
      in_last  = junk;
      if (out_valid) break;
      if (lat > 2000) begin
        check(0, "R5", "watchdog waiting for output", lat, 0);
        break;
      end
      @(posedge clk);
      lat++;
    end
    in_valid = 1'b0; in_last = 1'b0;
    seq_ok = 1'b1;
    got[0] = out_row;
    if (out_last) seq_ok = 1'b0;
    for (int i = 1; i < 16; i++) begin
      @(negedge clk);
      got[i] = out_row;
      if (!out_valid || (out_last != (i == 15))) seq_ok = 1'b0;
    end
    it = iters_used; rs = resid_words; fl = fail;
    check(seq_ok, "R8", "16-row output stream with last on row 15", int'(seq_ok), 1);
    @(negedge clk);
    check(!out_valid, "R8", "out_valid low after row 15", out_valid, 0);
  endtask

  task automatic cmp_frame(input frm_t a, input frm_t e, input string req, input string what);
    int bad; int ai; int ei;
    bad = 0; ai = 0; ei = 0;
    for (int r = 0; r < 16; r++) if (a[r] !== e[r]) begin
      if (bad == 0) begin ai = a[r]; ei = e[r]; end
      bad++;
    end
    check(bad == 0, req, what, ai, ei);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(out_valid == 0 && out_last == 0, "R10", "stream idle after reset", {out_valid, out_last}, 0);
    check(iters_used == 0 && fail == 0, "R10", "iters/fail cleared", {iters_used, fail}, 0);
    check(resid_words == 0, "R10", "resid cleared", resid_words, 0);
  endtask

  task automatic t_clean;
    frm_t f, g; int it, rs, fl, lat;
    make_frame(f);
    run_dec(f, 6, 0, g, it, rs, fl, lat);
    cmp_frame(g, f, "R2", "clean frame passes unchanged");
    check(it == 1, "R6", "clean frame stops after one iteration", it, 1);
    check(lat == 33, "R5", "latency for one iteration", lat, 33);
    check(rs == 0 && fl == 0, "R9", "clean frame status", rs * 2 + fl, 0);
  endtask

  task automatic t_single;
    frm_t f, x, g; int it, rs, fl, lat;
    make_frame(f); x = f;
    x[4][9] = ~x[4][9];
    x[10][0] = ~x[10][0];
    run_dec(x, 6, 0, g, it, rs, fl, lat);
    cmp_frame(g, f, "R3", "single errors per row incl. bit 0 corrected");
    check(it == 1, "R3", "single errors need one iteration", it, 1);
  endtask

  task automatic t_rowdouble;
    frm_t f, x, g; int it, rs, fl, lat;
    make_frame(f); x = f;
    x[6][3] = ~x[6][3];
    x[6][12] = ~x[6][12];
    run_dec(x, 6, 0, g, it, rs, fl, lat);
    cmp_frame(g, f, "R1", "row double cleared by column pass");
    check(it == 1 && fl == 0, "R1", "row double converges in one iteration", it, 1);
  endtask

  task automatic t_square;
    frm_t f, x, g; int it, rs, fl, lat;
    make_frame(f); x = f;
    x[2][5] = ~x[2][5];  x[2][13] = ~x[2][13];
    x[11][5] = ~x[11][5]; x[11][13] = ~x[11][13];
    run_dec(x, 3, 0, g, it, rs, fl, lat);
    cmp_frame(g, x, "R4", "2x2 square of double errors left unchanged");
    check(it == 3, "R7", "stuck frame runs to cap 3", it, 3);
    check(lat == 99, "R5", "latency for three iterations", lat, 99);
    check(fl == 1, "R9", "fail set on stuck frame", fl, 1);
    check(rs == 4, "R9", "resid words on square", rs, 4);
    run_dec(x, 7, 0, g, it, rs, fl, lat);
    check(it == 6, "R7", "cap 7 treated as 6", it, 6);
    check(lat == 198, "R5", "latency for six iterations", lat, 198);
  endtask

  task automatic two_iter_err(input frm_t f, output frm_t x);
    x = f;
    x[3][7] = ~x[3][7]; x[5][7] = ~x[5][7]; x[6][7] = ~x[6][7];
    x[3][10] = ~x[3][10]; x[5][11] = ~x[5][11]; x[6][12] = ~x[6][12];
  endtask

  task automatic t_two_iter;
    frm_t f, x, g, e; int it, rs, fl, lat, mit, mrs;
    make_frame(f);
    two_iter_err(f, x);
    run_dec(x, 6, 0, g, it, rs, fl, lat);
    cmp_frame(g, f, "R6", "two-iteration pattern corrected");
    check(it == 2, "R6", "early stop after second iteration", it, 2);
    check(lat == 66, "R5", "latency for two iterations", lat, 66);
    run_dec(x, 1, 0, g, it, rs, fl, lat);
    model(x, 1, e, mit, mrs);
    cmp_frame(g, e, "R7", "cap 1 output matches one iteration");
    check(it == 1 && fl == 1, "R7", "cap 1 stops unconverged", it * 2 + fl, 3);
    check(rs == 4, "R9", "resid after one iteration", rs, 4);
    run_dec(x, 0, 0, g, it, rs, fl, lat);
    check(it == 1, "R7", "cap 0 treated as 1", it, 1);
  endtask

  task automatic t_ignore;
    frm_t f, x, g; int it, rs, fl, lat;
    make_frame(f);
    two_iter_err(f, x);
    run_dec(x, 6, 1, g, it, rs, fl, lat);
    cmp_frame(g, f, "R2", "load beats during decode ignored");
    check(it == 2 && lat == 66, "R2", "timing unaffected by ignored beats", lat, 66);
  endtask

  task automatic t_random;
    frm_t f, x, g, e; int it, rs, fl, lat, mit, mrs, wt, mi;
    for (int n = 0; n < 20; n++) begin
      make_frame(f); x = f;
      wt = 1 + ($urandom % 5);
      mi = 1 + ($urandom % 6);
      for (int k = 0; k < wt; k++) begin
        int r; int c;
        r = $urandom % 16; c = $urandom % 16;
        x[r][c] = ~x[r][c];
      end
      model(x, mi, e, mit, mrs);
      run_dec(x, mi, 0, g, it, rs, fl, lat);
      cmp_frame(g, e, "R1", "random pattern output vs model");
      check(it == mit, "R6", "random pattern iterations", it, mit);
      check(rs == mrs && fl == (mrs != 0), "R9", "random pattern residual", rs, mrs);
      check(lat == 33 * mit, "R5", "random pattern latency", lat, 33 * mit);
    end
  endtask

  initial begin
    #1_600_000;
    check(0, "R5", "global watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_clean();
    t_single();
    t_rowdouble();
    t_square();
    t_two_iter();
    t_ignore();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule